// File: doc/BRIEF.md
# Register-Operation Execute Unit

This block is the execute stage of a small 8-bit controller for single-register and literal instructions. In each clock cycle it takes one 13-bit instruction word, the operand that the register file returns for that word's register field, the accumulator value and the incoming Z, C and DC flags. It covers several instruction groups:

- rotate through carry
- nibble exchange
- increment with conditional skip
- single-bit clear, set and test
- literal move, logic, add and subtract

One clock later it presents the registered result, a write strobe for either the accumulator or the register file (with the register address), the flag values the next instruction should see, and a skip request.

Flags that an instruction does not affect pass from the flag inputs to the flag outputs unchanged. Some words are outside these groups, such as jumps, calls, table returns and page or bank selects. Those words pass the flags through in the same way, raise no write strobe and raise no skip request. Fetch, program-counter control and the register file itself sit outside the block.

Top module: `rexu_core`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero after that edge.
- R2: Each output reflects the word presented before the most recent rising edge, with exactly one register stage. `wr_addr` carries instruction bits [5:0]. `wr_acc` and `wr_reg` are never high together.
- R3: Right rotate is `0_0110_0d_aaaaaa`, where d=0 targets the accumulator and d=1 targets the register. The result is {C, R[7:1]} and C becomes R[0]. Z and DC pass through.
- R4: Left rotate is `0_0110_1d_aaaaaa`, with the same d. The result is {R[6:0], C} and C becomes R[7]. Z and DC pass through.
- R5: Nibble exchange is `0_0111_0d_aaaaaa`. The result is {R[3:0], R[7:4]}, written to the accumulator (d=0) or the register (d=1). All flags pass through.
- R6: Increment is `0_0111_1d_aaaaaa`. The result is R+1 modulo 256, written per d. A skip is requested when that result is zero. All flags pass through, Z included.
- R7: Bit clear is `0_100i_iiaaaaaa` and bit set is `0_101i_iiaaaaaa`, with bit index iii. Each writes R to the register with bit iii cleared or set. All flags pass through.
- R8: Bit test is `0_110i_ii…` (skip if bit iii of R is 0) or `0_111i_ii…` (skip if it is 1). A bit test writes nothing and changes no flag.
- R9: Literal words are `1_1ooo_kkkkkkkk`. ooo=000 moves k to the accumulator with no flag change. Codes 001, 010 and 011 write A|k, A&k and A^k to the accumulator. Those three set Z exactly when the result is zero, and C and DC pass through.
- R10: ooo=101 writes k−A (mod 256) to the accumulator. Z is set exactly when the result is zero. C is 1 when k ≥ A, and DC is 1 when k[3:0] ≥ A[3:0].
- R11: ooo=111 writes k+A (mod 256) to the accumulator. Z is set exactly when the result is zero. C is the carry out of bit 7 and DC is the carry out of bit 3.
- R12: Any other word raises no write strobe and no skip, and all three flags pass through. This covers a top bit of 1 with bit 11 clear, ooo=100, ooo=110, and a top bit of 0 with bits [11:8] in 0000–0101.
- R13: `skip_next` reflects only the word of the previous cycle. It falls after one cycle when the next word does not itself request a skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_word | input | 13 | Instruction word being executed |
| rf_rdata | input | 8 | Register-file operand addressed by ins_word[5:0] |
| acc | input | 8 | Current accumulator |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| dc_in | input | 1 | Current digit-carry flag |
| result | output | 8 | Registered result value |
| wr_acc | output | 1 | Write result to the accumulator |
| wr_reg | output | 1 | Write result to the register file |
| wr_addr | output | 6 | Register-file write address |
| z_out | output | 1 | Updated zero flag |
| c_out | output | 1 | Updated carry flag |
| dc_out | output | 1 | Updated digit-carry flag |
| skip_next | output | 1 | Request to skip the following instruction |

## Verification
The bound checker watches several properties on every cycle:

- the two write strobes are exclusive
- a skip request comes only from an increment or a bit test
- unrecognised words stay silent
- the carry after a rotate comes from the right end of the operand
- the add result and carry match the previous cycle's inputs

Several behaviours can only be shown by the bench's vectors: rotate and exchange results, the flag pass-through for each group, and the subtract borrow conventions at the nibble and byte boundaries. The same holds for the bit position each index selects, the skip on an all-ones increment, and reset while a skipping word is presented.

// File: rtl/rexu_pkg.sv
package rexu_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ROT,
    OP_SWAP,
    OP_INC,
    OP_BCLR,
    OP_BSET,
    OP_BTST0,
    OP_BTST1,
    OP_LIT_MOV,
    OP_LIT_LOGIC,
    OP_LIT_SUB,
    OP_LIT_ADD
  } op_e;

  typedef struct packed {
    op_e  op;
    logic to_reg;
    logic left;
  } dec_t;

  typedef enum logic [2:0] {
    LS_MOV = 3'b000,
    LS_OR  = 3'b001,
    LS_AND = 3'b010,
    LS_XOR = 3'b011,
    LS_SUB = 3'b101,
    LS_ADD = 3'b111
  } lit_sel_e;

endpackage

// File: rtl/rexu_decode.sv
module rexu_decode
  import rexu_pkg::*;
(
  input  logic [12:6] hi_bits,
  output dec_t        dec
);

  always_comb begin
    dec = '{op: OP_NONE, to_reg: 1'b0, left: 1'b0};
    if (!hi_bits[12]) begin
      if (hi_bits[11]) begin
        unique case (hi_bits[10:9])
          2'b00:   dec.op = OP_BCLR;
          2'b01:   dec.op = OP_BSET;
          2'b10:   dec.op = OP_BTST0;
          default: dec.op = OP_BTST1;
        endcase
        dec.to_reg = (hi_bits[10:9] == 2'b00) || (hi_bits[10:9] == 2'b01);
      end else if (hi_bits[11:8] == 4'b0110) begin
        dec.op     = OP_ROT;
        dec.left   = hi_bits[7];
        dec.to_reg = hi_bits[6];
      end else if (hi_bits[11:8] == 4'b0111) begin
        dec.op     = hi_bits[7] ? OP_INC : OP_SWAP;
        dec.to_reg = hi_bits[6];
      end
    end else if (hi_bits[11]) begin
      case (hi_bits[10:8])
        LS_MOV:                 dec.op = OP_LIT_MOV;
        LS_OR, LS_AND, LS_XOR:  dec.op = OP_LIT_LOGIC;
        LS_SUB:                 dec.op = OP_LIT_SUB;
        LS_ADD:                 dec.op = OP_LIT_ADD;
        default:                dec.op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/rexu_shift_unit.sv
module rexu_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic              cin,
  input  logic              left,
  output logic [DATA_W-1:0] rot_res,
  output logic              rot_c,
  output logic [DATA_W-1:0] swap_res,
  output logic [DATA_W-1:0] inc_res,
  output logic              inc_zero
);

  localparam int NIB = DATA_W / 2;

  always_comb begin
    if (left) begin
      rot_res = {opnd[DATA_W-2:0], cin};
      rot_c   = opnd[DATA_W-1];
    end else begin
      rot_res = {cin, opnd[DATA_W-1:1]};
      rot_c   = opnd[0];
    end
  end

  assign swap_res = {opnd[NIB-1:0], opnd[DATA_W-1:NIB]};
  assign inc_res  = opnd + {{(DATA_W-1){1'b0}}, 1'b1};
  assign inc_zero = (inc_res == '0);

endmodule

// File: rtl/rexu_bit_unit.sv
module rexu_bit_unit #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] clr_res,
  output logic [DATA_W-1:0] set_res,
  output logic              bit_val
);

  logic [DATA_W-1:0] sel_mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign sel_mask[g] = (idx == IDX_W'(g));
  end

  assign clr_res = opnd & ~sel_mask;
  assign set_res = opnd | sel_mask;
  assign bit_val = |(opnd & sel_mask);

endmodule

// File: rtl/rexu_lit_alu.sv
module rexu_lit_alu
  import rexu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lit,
  input  logic [DATA_W-1:0] acc,
  input  logic [2:0]        sel,
  output logic [DATA_W-1:0] res,
  output logic              zf,
  output logic              cf,
  output logic              dcf
);

  localparam int NIB = DATA_W / 2;

  logic [DATA_W:0] sum_w, dif_w;
  logic [NIB:0]    sum_n, dif_n;

  always_comb begin
    sum_w = {1'b0, lit} + {1'b0, acc};
    dif_w = {1'b0, lit} + {1'b0, ~acc} + {{DATA_W{1'b0}}, 1'b1};
    sum_n = {1'b0, lit[NIB-1:0]} + {1'b0, acc[NIB-1:0]};
    dif_n = {1'b0, lit[NIB-1:0]} + {1'b0, ~acc[NIB-1:0]} + {{NIB{1'b0}}, 1'b1};
    cf    = 1'b0;
    dcf   = 1'b0;
    case (sel)
      LS_OR:   res = acc | lit;
      LS_AND:  res = acc & lit;
      LS_XOR:  res = acc ^ lit;
      LS_SUB:  begin res = dif_w[DATA_W-1:0]; cf = dif_w[DATA_W]; dcf = dif_n[NIB]; end
      LS_ADD:  begin res = sum_w[DATA_W-1:0]; cf = sum_w[DATA_W]; dcf = sum_n[NIB]; end
      default: res = lit;
    endcase
    zf = (res == '0);
  end

endmodule

// File: rtl/rexu_core.sv
module rexu_core
  import rexu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int INSN_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] ins_word,
  input  logic [DATA_W-1:0] rf_rdata,
  input  logic [DATA_W-1:0] acc,
  input  logic              z_in,
  input  logic              c_in,
  input  logic              dc_in,
  output logic [DATA_W-1:0] result,
  output logic              wr_acc,
  output logic              wr_reg,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              z_out,
  output logic              c_out,
  output logic              dc_out,
  output logic              skip_next
);

  localparam int IDX_W = $clog2(DATA_W);

  dec_t dec;
  logic [DATA_W-1:0] rot_res, swap_res, inc_res, clr_res, set_res, alu_res;
  logic rot_c, inc_zero, bit_val, alu_z, alu_c, alu_dc;

  logic [DATA_W-1:0] n_res;
  logic n_wa, n_wr, n_z, n_c, n_dc, n_skip;

  rexu_decode u_dec (
    .hi_bits (ins_word[12:6]),
    .dec     (dec)
  );

  rexu_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .opnd     (rf_rdata),
    .cin      (c_in),
    .left     (dec.left),
    .rot_res  (rot_res),
    .rot_c    (rot_c),
    .swap_res (swap_res),
    .inc_res  (inc_res),
    .inc_zero (inc_zero)
  );

  rexu_bit_unit #(.DATA_W(DATA_W)) u_bit (
    .opnd    (rf_rdata),
    .idx     (ins_word[ADDR_W +: IDX_W]),
    .clr_res (clr_res),
    .set_res (set_res),
    .bit_val (bit_val)
  );

  rexu_lit_alu #(.DATA_W(DATA_W)) u_alu (
    .lit (ins_word[DATA_W-1:0]),
    .acc (acc),
    .sel (ins_word[10:8]),
    .res (alu_res),
    .zf  (alu_z),
    .cf  (alu_c),
    .dcf (alu_dc)
  );

  always_comb begin
    n_res  = '0;
    n_wa   = 1'b0;
    n_wr   = 1'b0;
    n_z    = z_in;
    n_c    = c_in;
    n_dc   = dc_in;
    n_skip = 1'b0;
    case (dec.op)
      OP_ROT: begin
        n_res = rot_res;
        n_c   = rot_c;
        n_wr  = dec.to_reg;
        n_wa  = !dec.to_reg;
      end
      OP_SWAP: begin
        n_res = swap_res;
        n_wr  = dec.to_reg;
        n_wa  = !dec.to_reg;
      end
      OP_INC: begin
        n_res  = inc_res;
        n_wr   = dec.to_reg;
        n_wa   = !dec.to_reg;
        n_skip = inc_zero;
      end
      OP_BCLR: begin
        n_res = clr_res;
        n_wr  = 1'b1;
      end
      OP_BSET: begin
        n_res = set_res;
        n_wr  = 1'b1;
      end
      OP_BTST0: n_skip = !bit_val;
      OP_BTST1: n_skip = bit_val;
      OP_LIT_MOV: begin
        n_res = alu_res;
        n_wa  = 1'b1;
      end
      OP_LIT_LOGIC: begin
        n_res = alu_res;
        n_wa  = 1'b1;
        n_z   = alu_z;
      end
      OP_LIT_SUB, OP_LIT_ADD: begin
        n_res = alu_res;
        n_wa  = 1'b1;
        n_z   = alu_z;
        n_c   = alu_c;
        n_dc  = alu_dc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      wr_acc    <= 1'b0;
      wr_reg    <= 1'b0;
      wr_addr   <= '0;
      z_out     <= 1'b0;
      c_out     <= 1'b0;
      dc_out    <= 1'b0;
      skip_next <= 1'b0;
    end else begin
      result    <= n_res;
      wr_acc    <= n_wa;
      wr_reg    <= n_wr;
      wr_addr   <= ins_word[ADDR_W-1:0];
      z_out     <= n_z;
      c_out     <= n_c;
      dc_out    <= n_dc;
      skip_next <= n_skip;
    end
  end

endmodule

// File: rtl/rexu_core_chk.sv
module rexu_core_chk #(
  parameter int DATA_W = 8,
  parameter int INSN_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic [INSN_W-1:0] ins_word,
  input logic [DATA_W-1:0] rf_rdata,
  input logic [DATA_W-1:0] acc,
  input logic              z_in,
  input logic              c_in,
  input logic              dc_in,
  input logic [DATA_W-1:0] result,
  input logic              wr_acc,
  input logic              wr_reg,
  input logic              z_out,
  input logic              c_out,
  input logic              dc_out,
  input logic              skip_next
);

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  function automatic logic is_unrec(input logic [INSN_W-1:0] w);
    if (!w[12]) return !w[11] && (w[11:8] != 4'b0110) && (w[11:8] != 4'b0111);
    return !w[11] || (w[10:8] == 3'b100) || (w[10:8] == 3'b110);
  endfunction

  function automatic logic may_skip(input logic [INSN_W-1:0] w);
    return (w[12:7] == 6'b001111) || (w[12:10] == 3'b011);
  endfunction

  p_dest_excl_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    !(wr_acc && wr_reg));

  p_unrec_quiet_r12: assert property (@(posedge clk) disable iff (rst || !armed)
    is_unrec($past(ins_word)) |-> (!wr_acc && !wr_reg && !skip_next &&
      z_out == $past(z_in) && c_out == $past(c_in) && dc_out == $past(dc_in)));

  p_skip_src_r13: assert property (@(posedge clk) disable iff (rst || !armed)
    skip_next |-> may_skip($past(ins_word)));

  p_rotr_carry_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(ins_word[12:7]) == 6'b001100) |-> (c_out == $past(rf_rdata[0])));

  p_rotl_carry_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(ins_word[12:7]) == 6'b001101) |-> (c_out == $past(rf_rdata[DATA_W-1])));

  p_add_sum_r11: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(ins_word[12:8]) == 5'b11111) |->
      ({c_out, result} == $past({1'b0, ins_word[DATA_W-1:0]} + {1'b0, acc})));

endmodule

bind rexu_core rexu_core_chk #(.DATA_W(DATA_W), .INSN_W(INSN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ins_word  (ins_word),
  .rf_rdata  (rf_rdata),
  .acc       (acc),
  .z_in      (z_in),
  .c_in      (c_in),
  .dc_in     (dc_in),
  .result    (result),
  .wr_acc    (wr_acc),
  .wr_reg    (wr_reg),
  .z_out     (z_out),
  .c_out     (c_out),
  .dc_out    (dc_out),
  .skip_next (skip_next)
);

// File: tb/rexu_core_test.sv
`timescale 1ns/1ps
module rexu_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] ins_word = '0;
  logic [7:0]  rf_rdata = '0;
  logic [7:0]  acc = '0;
  logic        z_in = 1'b0, c_in = 1'b0, dc_in = 1'b0;
  logic [7:0]  result;
  logic        wr_acc, wr_reg, z_out, c_out, dc_out, skip_next;
  logic [5:0]  wr_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rexu_core uut (
    .clk(clk), .rst(rst), .ins_word(ins_word), .rf_rdata(rf_rdata), .acc(acc),
    .z_in(z_in), .c_in(c_in), .dc_in(dc_in), .result(result), .wr_acc(wr_acc),
    .wr_reg(wr_reg), .wr_addr(wr_addr), .z_out(z_out), .c_out(c_out),
    .dc_out(dc_out), .skip_next(skip_next)
  );

  // {word, operand, acc, zcd_in, exp_res, exp_wa, exp_wr, exp_zcd, exp_skip}
  localparam int NV = 27;
  localparam logic [45:0] VEC [NV] = '{
    {13'h0605, 8'h81, 8'h00, 3'b000, 8'h40, 1'b1, 1'b0, 3'b010, 1'b0},
    {13'h0643, 8'h02, 8'h00, 3'b111, 8'h81, 1'b0, 1'b1, 3'b101, 1'b0},
    {13'h0680, 8'h80, 8'h00, 3'b010, 8'h01, 1'b1, 1'b0, 3'b010, 1'b0},
    {13'h06C1, 8'h55, 8'h00, 3'b001, 8'hAA, 1'b0, 1'b1, 3'b001, 1'b0},
    {13'h0702, 8'h3C, 8'h00, 3'b101, 8'hC3, 1'b1, 1'b0, 3'b101, 1'b0},
    {13'h0742, 8'hA5, 8'h00, 3'b010, 8'h5A, 1'b0, 1'b1, 3'b010, 1'b0},
    {13'h0781, 8'hFF, 8'h00, 3'b000, 8'h00, 1'b1, 1'b0, 3'b000, 1'b1},
    {13'h07C1, 8'h10, 8'h00, 3'b111, 8'h11, 1'b0, 1'b1, 3'b111, 1'b0},
    {13'h09C0, 8'hFF, 8'h00, 3'b000, 8'h7F, 1'b0, 1'b1, 3'b000, 1'b0},
    {13'h0A81, 8'h00, 8'h00, 3'b000, 8'h04, 1'b0, 1'b1, 3'b000, 1'b0},
    {13'h0CC0, 8'hF7, 8'h00, 3'b100, 8'h00, 1'b0, 1'b0, 3'b100, 1'b1},
    {13'h0E00, 8'h01, 8'h00, 3'b010, 8'h00, 1'b0, 1'b0, 3'b010, 1'b1},
    {13'h0E00, 8'h00, 8'h00, 3'b010, 8'h00, 1'b0, 1'b0, 3'b010, 1'b0},
    {13'h185A, 8'h00, 8'h00, 3'b111, 8'h5A, 1'b1, 1'b0, 3'b111, 1'b0},
    {13'h1900, 8'h00, 8'h00, 3'b010, 8'h00, 1'b1, 1'b0, 3'b110, 1'b0},
    {13'h1A0F, 8'h00, 8'hF0, 3'b001, 8'h00, 1'b1, 1'b0, 3'b101, 1'b0},
    {13'h1BFF, 8'h00, 8'h0F, 3'b111, 8'hF0, 1'b1, 1'b0, 3'b011, 1'b0},
    {13'h1D10, 8'h00, 8'h01, 3'b101, 8'h0F, 1'b1, 1'b0, 3'b010, 1'b0},
    {13'h1D05, 8'h00, 8'h05, 3'b000, 8'h00, 1'b1, 1'b0, 3'b111, 1'b0},
    {13'h1D00, 8'h00, 8'h01, 3'b111, 8'hFF, 1'b1, 1'b0, 3'b000, 1'b0},
    {13'h1F88, 8'h00, 8'h88, 3'b000, 8'h10, 1'b1, 1'b0, 3'b011, 1'b0},
    {13'h1F01, 8'h00, 8'hFF, 3'b000, 8'h00, 1'b1, 1'b0, 3'b111, 1'b0},
    {13'h1F12, 8'h00, 8'h34, 3'b111, 8'h46, 1'b1, 1'b0, 3'b000, 1'b0},
    {13'h0000, 8'hAA, 8'h55, 3'b101, 8'h00, 1'b0, 1'b0, 3'b101, 1'b0},
    {13'h1C33, 8'hAA, 8'h55, 3'b010, 8'h00, 1'b0, 1'b0, 3'b010, 1'b0},
    {13'h1400, 8'hAA, 8'h55, 3'b111, 8'h00, 1'b0, 1'b0, 3'b111, 1'b0},
    {13'h1E81, 8'hAA, 8'h55, 3'b000, 8'h00, 1'b0, 1'b0, 3'b000, 1'b0}
  };

  function automatic string req_of(input int i);
    if (i <= 0)  return "R3";
    if (i == 1)  return "R3";
    if (i <= 3)  return "R4";
    if (i <= 5)  return "R5";
    if (i <= 7)  return "R6";
    if (i <= 9)  return "R7";
    if (i <= 12) return "R8";
    if (i <= 16) return "R9";
    if (i <= 19) return "R10";
    if (i <= 22) return "R11";
    return "R12";
  endfunction

  task automatic drive(input logic [12:0] w, input logic [7:0] r, input logic [7:0] a,
                       input logic [2:0] f);
    ins_word = w; rf_rdata = r; acc = a; {z_in, c_in, dc_in} = f;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset while a skipping, writing word is presented
    drive(13'h0781, 8'hFF, 8'h00, 3'b111);
    repeat (3) @(negedge clk);
    check("R1", {result, wr_acc, wr_reg, wr_addr, z_out, c_out, dc_out, skip_next}, '0);
    rst = 1'b0;

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      logic [7:0] act_res, exp_res;
      v = VEC[i];
      drive(v[45:33], v[32:25], v[24:17], v[16:14]);
      @(negedge clk);
      exp_res = (v[5] || v[4]) ? v[13:6] : 8'h00;
      act_res = (v[5] || v[4]) ? result : 8'h00;
      check(req_of(i), {act_res, wr_acc, wr_reg, z_out, c_out, dc_out, skip_next},
            {exp_res, v[5:0]});
    end

    // R2: one register stage, write address from bits [5:0]
    drive(13'h0643, 8'h02, 8'h00, 3'b000);
    @(negedge clk);
    drive(13'h0000, 8'h00, 8'h00, 3'b000);
    #1;
    check("R2", {wr_reg, wr_addr}, {1'b1, 6'd3});
    @(negedge clk);
    check("R2", {wr_reg, wr_acc}, 2'b00);

    // R13: skip pulse lasts one cycle when the next word does not skip
    drive(13'h07C1, 8'hFF, 8'h00, 3'b000);
    @(negedge clk);
    check("R13", {skip_next, result}, {1'b1, 8'h00});
    drive(13'h07C1, 8'h00, 8'h00, 3'b000);
    @(negedge clk);
    check("R13", {skip_next, result}, {1'b0, 8'h01});

    // R8: bit test on highest index, both polarities
    drive(13'h0FC0, 8'h80, 8'h00, 3'b000);
    @(negedge clk);
    check("R8", {skip_next, wr_acc, wr_reg}, 3'b100);
    drive(13'h0DC0, 8'h80, 8'h00, 3'b000);
    @(negedge clk);
    check("R8", {skip_next, wr_acc, wr_reg}, 3'b000);

    // R1: reset asserted mid-stream clears outputs
    drive(13'h1F01, 8'h00, 8'hFF, 3'b000);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {result, wr_acc, z_out, c_out, dc_out}, '0);
    rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule